// File: doc/BRIEF.md
# Cycle Clock Failure Monitor

This block watches the instruction-cycle clock of a small controller and reports when that clock has stopped or runs far too slowly. The cycle-clock domain presents a signal that flips once per instruction cycle. The monitor brings that toggle into its own domain through a short synchronizer chain. It then checks, against an independent slow reference tick, that every reference interval contains at least one toggle edge. If a complete interval passes with no edge, the monitor raises an error status and requests that the shared active-low fault pin be pulled low. The same pin also carries the watchdog's request, so the block ORs the two requests into one output.

The error is sticky. It clears only after a run of consecutive reference intervals that each contain an edge. Even then the pin stays pulled low for a further fixed number of recovered cycles, counted as synchronized toggle edges. The monitor comes out of reset enabled. The watchdog's first accepted service write carries a select bit, and the monitor commits that bit as its enable. Later service writes cannot change it until the next reset.

With the reference interval sized between about 0.1 ms and 100 ms, a cycle clock of 10 kHz or more always lands edges in every interval and is never flagged. A clock below 10 Hz, or one that never starts, leaves intervals empty and is always flagged.

Top module: `cycle_clock_monitor`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `clkErr` is 0 and the monitor requests no pull-low. After reset the monitor is enabled.
- R2: An interval is counted only between two `refTick` pulses, so the stretch before the first tick after reset is never judged. When `MISS_INTERVALS` consecutive complete intervals (default 1) contain no synchronized edge, `clkErr` and `pullLow` go to 1 on the cycle after the tick that ends the last such interval.
- R3: Any interval that contains at least one synchronized edge clears the count of empty intervals. A cycle clock that produces at least one edge in every interval is never flagged.
- R4: A cycle clock that never starts produces a continuous error: `clkErr` and `pullLow` stay 1 for as long as intervals remain empty. `clkErr` is never 1 without `pullLow`.
- R5: Once in error, `clkErr` stays 1 until `RECOVER_INTERVALS` (default 4) consecutive intervals each contain an edge. On the tick that ends the last of these, `clkErr` drops to 0 while the pull-low request remains.
- R6: After recovery the pull-low request is held until `RELEASE_EDGES` (default 16) more synchronized edges arrive, and then it is dropped. Each toggle edge counts as one cycle.
- R7: An empty interval while the release is being held returns the monitor to error (`clkErr` = 1), and the recovery count starts again.
- R8: `pullLow` is 1 whenever `wdPullReq` is 1, independent of the monitor state, and follows it combinationally.
- R9: Only the first `svcCommit` pulse after reset is taken: it loads `svcMonSel` (1 = enabled, 0 = disabled) as the enable. Every later pulse is ignored until the next reset.
- R10: While disabled, the monitor requests no pull-low and reports no error. An active error or release hold is dropped on the cycle after the enable goes to 0.
- R11: `cycToggle` passes through `SYNC_STAGES` (default 2) flops before edge detection. Rising and falling toggle edges both count as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor (reference-domain) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle pulse marking each reference interval boundary |
| cycToggle | input | 1 | Toggle from the instruction-cycle domain, flips once per cycle |
| svcCommit | input | 1 | Pulse for an accepted watchdog service write |
| svcMonSel | input | 1 | Monitor enable select carried by that service write |
| wdPullReq | input | 1 | Watchdog's pull-low request for the shared pin |
| pullLow | output | 1 | Combined request to drive the shared active-low pin low |
| clkErr | output | 1 | Clock failure status |

## Verification
The bound checker covers the behaviour that holds on every cycle. An error can only begin on a reference tick. The error status always implies the pull-low request. Recovery from error happens only on a tick. The release happens only on a synchronized edge or because the monitor was disabled. A disabled monitor stays disabled and silent.

Some behaviour is visible only in the bench's scenarios, which track how the outputs develop over many intervals:
- the first partial interval is not judged;
- the error persists while the clock stays dead;
- exactly four good intervals clear the status;
- the pin is released on the sixteenth edge and not the fifteenth;
- an empty interval during the hold falls back to error;
- only the first service write changes the enable.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  typedef enum logic [1:0] {
    MON_WATCH = 2'd0,
    MON_FAULT = 2'd1,
    MON_HOLD  = 2'd2
  } monState_e;

  // control -> datapath: which counter runs
  typedef struct packed {
    logic watchEn;
    logic goodEn;
    logic holdEn;
  } monStrobe_t;

  // datapath -> control: interval and count events
  typedef struct packed {
    logic tickEmpty;
    logic missHit;
    logic goodHit;
    logic holdDone;
  } monEvent_t;

endpackage

// File: rtl/clkmon_datapath.sv
module clkmon_datapath
  import clkmon_pkg::*;
#(
  parameter int SYNC_STAGES       = 2,
  parameter int MISS_INTERVALS    = 1,
  parameter int RECOVER_INTERVALS = 4,
  parameter int RELEASE_EDGES     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       cycToggle,
  input  logic       svcCommit,
  input  logic       svcMonSel,
  input  monStrobe_t strobe,
  output monEvent_t  evt,
  output logic       monEn,
  output logic       edgePulse
);

  localparam int MISS_W = $clog2(MISS_INTERVALS + 1);
  localparam int GOOD_W = $clog2(RECOVER_INTERVALS + 1);
  localparam int HOLD_W = $clog2(RELEASE_EDGES + 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_INTERVALS - 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(RECOVER_INTERVALS - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RELEASE_EDGES - 1);

  // synchronizer chain (R11)
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= cycToggle;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[SYNC_STAGES-1];
  end

  assign edgePulse = syncQ[SYNC_STAGES-1] ^ lastQ;

  // interval bookkeeping
  logic armed;
  logic seenEdge;
  logic hasEdge;
  logic tickFull;
  logic tickEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      seenEdge <= 1'b0;
    end else if (refTick) begin
      armed    <= 1'b1;
      seenEdge <= 1'b0;
    end else if (edgePulse) begin
      seenEdge <= 1'b1;
    end
  end

  assign hasEdge   = seenEdge | edgePulse;
  assign tickFull  = refTick & armed & hasEdge;
  assign tickEmpty = refTick & armed & ~hasEdge;

  // consecutive empty intervals while watching
  logic [MISS_W-1:0] missCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          missCnt <= '0;
    else if (!strobe.watchEn || tickFull) missCnt <= '0;
    else if (tickEmpty)                 missCnt <= missCnt + MISS_W'(1);
  end

  // consecutive good intervals while in fault
  logic [GOOD_W-1:0] goodCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           goodCnt <= '0;
    else if (!strobe.goodEn || tickEmpty) goodCnt <= '0;
    else if (tickFull)                   goodCnt <= goodCnt + GOOD_W'(1);
  end

  // recovered edges while holding the pin
  logic [HOLD_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (!strobe.holdEn) holdCnt <= '0;
    else if (edgePulse)      holdCnt <= holdCnt + HOLD_W'(1);
  end

  // one-time enable commit (R9)
  logic committed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monEn     <= 1'b1;
      committed <= 1'b0;
    end else if (svcCommit && !committed) begin
      monEn     <= svcMonSel;
      committed <= 1'b1;
    end
  end

  assign evt.tickEmpty = tickEmpty;
  assign evt.missHit   = tickEmpty & (missCnt == MISS_LAST);
  assign evt.goodHit   = tickFull & (goodCnt == GOOD_LAST);
  assign evt.holdDone  = edgePulse & (holdCnt == HOLD_LAST);

endmodule

// File: rtl/clkmon_control.sv
module clkmon_control
  import clkmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       monEn,
  input  monEvent_t  evt,
  output monStrobe_t strobe,
  output logic       monPull,
  output logic       clkErr
);

  monState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      MON_WATCH: if (monEn && evt.missHit) stateNext = MON_FAULT;
      MON_FAULT: begin
        if (!monEn)           stateNext = MON_WATCH;
        else if (evt.goodHit) stateNext = MON_HOLD;
      end
      MON_HOLD: begin
        if (!monEn)             stateNext = MON_WATCH;
        else if (evt.tickEmpty) stateNext = MON_FAULT;
        else if (evt.holdDone)  stateNext = MON_WATCH;
      end
      default: stateNext = MON_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MON_WATCH;
    else       state <= stateNext;
  end

  assign strobe.watchEn = (state == MON_WATCH) & monEn;
  assign strobe.goodEn  = (state == MON_FAULT);
  assign strobe.holdEn  = (state == MON_HOLD);

  assign monPull = (state != MON_WATCH);
  assign clkErr  = (state == MON_FAULT);

endmodule

// File: rtl/cycle_clock_monitor.sv
module cycle_clock_monitor
  import clkmon_pkg::*;
#(
  parameter int SYNC_STAGES       = 2,
  parameter int MISS_INTERVALS    = 1,
  parameter int RECOVER_INTERVALS = 4,
  parameter int RELEASE_EDGES     = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic refTick,
  input  logic cycToggle,
  input  logic svcCommit,
  input  logic svcMonSel,
  input  logic wdPullReq,
  output logic pullLow,
  output logic clkErr
);

  monStrobe_t strobe;
  monEvent_t  evt;
  logic       monEn;
  logic       edgePulse;
  logic       monPull;

  clkmon_datapath #(
    .SYNC_STAGES      (SYNC_STAGES),
    .MISS_INTERVALS   (MISS_INTERVALS),
    .RECOVER_INTERVALS(RECOVER_INTERVALS),
    .RELEASE_EDGES    (RELEASE_EDGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .cycToggle(cycToggle),
    .svcCommit(svcCommit),
    .svcMonSel(svcMonSel),
    .strobe   (strobe),
    .evt      (evt),
    .monEn    (monEn),
    .edgePulse(edgePulse)
  );

  clkmon_control u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .monEn  (monEn),
    .evt    (evt),
    .strobe (strobe),
    .monPull(monPull),
    .clkErr (clkErr)
  );

  // shared active-low pin request (R8)
  assign pullLow = monPull | wdPullReq;

endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker (
  input logic clk,
  input logic rstN,
  input logic refTick,
  input logic clkErr,
  input logic monPull,
  input logic monEn,
  input logic edgePulse
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (!clkErr && !monPull));

  assert_fault_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkErr) |-> $past(refTick));

  assert_err_implies_pull_R4: assert property (@(posedge clk) disable iff (!rstN)
    clkErr |-> monPull);

  assert_recover_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(clkErr) && monPull) |-> $past(refTick));

  assert_release_on_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(monPull) |-> ($past(edgePulse) || !$past(monEn)));

  assert_enable_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !monEn |=> !monEn);

  assert_disabled_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    !monEn |=> !monPull);

endmodule

bind cycle_clock_monitor clkmon_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .refTick  (refTick),
  .clkErr   (clkErr),
  .monPull  (monPull),
  .monEn    (monEn),
  .edgePulse(edgePulse)
);

// File: tb/tb_cycle_clock_monitor.sv
`timescale 1ns/1ps
module tb_cycle_clock_monitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic cycToggle = 1'b0;
  logic svcCommit = 1'b0;
  logic svcMonSel = 1'b0;
  logic wdPullReq = 1'b0;
  logic pullLow;
  logic clkErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    bit    expPull;
    bit    expErr;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  cycle_clock_monitor dut (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .cycToggle(cycToggle),
    .svcCommit(svcCommit),
    .svcMonSel(svcMonSel),
    .wdPullReq(wdPullReq),
    .pullLow  (pullLow),
    .clkErr   (clkErr)
  );

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        testsRun++;
        if (pullLow !== it.expPull || clkErr !== it.expErr) begin
          testsFailed++;
          $display("FAIL %s: pullLow=%0b clkErr=%0b expected pullLow=%0b clkErr=%0b",
                   it.tag, pullLow, clkErr, it.expPull, it.expErr);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectOut(input string tag, input bit p, input bit e);
    expItem_t it;
    it.tag = tag;
    it.expPull = p;
    it.expErr = e;
    expQ.push_back(it);
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) begin
      cycToggle = ~cycToggle;
      step(3);
    end
    step(2);
  endtask

  task automatic tick();
    refTick = 1'b1;
    step(1);
    refTick = 1'b0;
  endtask

  task automatic interval(input int nEdges);
    toggles(nEdges);
    step(4);
    tick();
  endtask

  task automatic commit(input bit sel);
    svcMonSel = sel;
    svcCommit = 1'b1;
    step(1);
    svcCommit = 1'b0;
    step(2);
  endtask

  initial begin
    step(5);
    expectOut("R1 reset quiet", 1'b0, 1'b0);
    rstN = 1'b1;
    step(1);
    expectOut("R1 after reset", 1'b0, 1'b0);

    // never-started clock
    interval(0);
    expectOut("R2 first partial interval not judged", 1'b0, 1'b0);
    interval(0);
    expectOut("R2 empty interval flags", 1'b1, 1'b1);
    interval(0); interval(0); interval(0);
    expectOut("R4 continuous error", 1'b1, 1'b1);

    // recovery
    interval(1); interval(1); interval(1);
    expectOut("R5 still in error after 3 good", 1'b1, 1'b1);
    interval(1);
    expectOut("R5 status clears after 4 good", 1'b1, 1'b0);
    toggles(15);
    expectOut("R6 hold after 15 edges (R11 both polarities)", 1'b1, 1'b0);
    toggles(1);
    expectOut("R6 release on 16th edge", 1'b0, 1'b0);

    // slow but valid clock and fast clock
    interval(1); interval(1); interval(1); interval(1); interval(1);
    expectOut("R3 one edge per interval never flagged", 1'b0, 1'b0);
    interval(8); interval(8); interval(8);
    expectOut("R3 fast clock never flagged", 1'b0, 1'b0);

    // watchdog request passes through
    wdPullReq = 1'b1;
    step(1);
    expectOut("R8 watchdog request drives pin", 1'b1, 1'b0);
    wdPullReq = 1'b0;
    step(1);
    expectOut("R8 watchdog request released", 1'b0, 1'b0);

    // empty interval during hold
    interval(0);
    expectOut("R7 fault again", 1'b1, 1'b1);
    interval(1); interval(1); interval(1); interval(1);
    expectOut("R7 hold entered", 1'b1, 1'b0);
    tick();
    expectOut("R7 empty interval during hold returns to error", 1'b1, 1'b1);
    interval(1); interval(1); interval(1); interval(1);
    toggles(16);
    expectOut("R7 recovered again", 1'b0, 1'b0);

    // first commit keeps enable, second is ignored
    commit(1'b1);
    commit(1'b0);
    interval(0);
    interval(0);
    expectOut("R9 later commit ignored, monitor still flags", 1'b1, 1'b1);

    // new reset: disable while faulted
    rstN = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
    interval(0);
    interval(0);
    expectOut("R2 flags after second reset", 1'b1, 1'b1);
    commit(1'b0);
    expectOut("R10 disable drops active error", 1'b0, 1'b0);
    commit(1'b1);
    interval(0); interval(0); interval(0);
    expectOut("R9 re-enable ignored, R10 stays silent", 1'b0, 1'b0);
    wdPullReq = 1'b1;
    step(1);
    expectOut("R8 watchdog request while monitor disabled", 1'b1, 1'b0);
    wdPullReq = 1'b0;
    step(2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule